// File: doc/BRIEF.md
# Video Processor Control Port Decoder

This block sits behind the 16-bit control port of a tile-based video processor. Every control-port write is one of two things. It is either a single-word command that loads one of the processor's internal registers, or one half of a two-word command that selects a memory address and an access mode for later data-port transfers. A pending flag remembers that the first half of an address command has arrived. While that flag is set, the next control write is always taken as the second half.

When the second half arrives, the block assembles a 16-bit address and a 6-bit access code. It classifies the code as a read or write of video RAM, colour RAM or vertical-scroll RAM, or as a DMA request. It registers these results together with a one-cycle completion strobe. Reading the port returns a status word built from FIFO and display-state flags. The downstream memories, data-port engine and DMA engine consume these outputs; they are not part of this block.

Top module: `vpc_ctrl_port`

## Requirements
- R1: A control write with no pending first word and bits 15:14 equal to 2'b10 is a register command. On the next cycle `reg_wr` is high for one cycle, `reg_idx` equals bits 12:8 and `reg_val` equals bits 7:0, and `word_pending` stays low.
- R2: A control write with no pending first word and bits 15:14 not equal to 2'b10 is a first address word. It sets `word_pending` on the next cycle and leaves `addr`, `acc_code` and the classification outputs unchanged.
- R3: Any control write while `word_pending` is high is the second word, whatever its top bits. On the next cycle `addr` = {second[1:0], first[13:0]}, `acc_code` = {second[7:4], first[15:14]}, and `word_pending` is low. Bits 15:8 and 3:2 of the second word are ignored.
- R4: A status read or a data-port write in a cycle without a control write clears `word_pending` on the next cycle. A control write in the same cycle takes precedence and is decoded normally.
- R5: For codes with bit 5 clear, the table is: 000001 gives video RAM write, 000011 gives colour RAM write, 000101 gives scroll RAM write, 000000 gives video RAM read, 001000 gives colour RAM read and 000100 gives scroll RAM read. `mem_sel` encodes none=0, video=1, colour=2, scroll=3, and `acc_write` marks the write codes.
- R6: A code with bit 5 set is a DMA request. `dma_req` is 1, `dma_copy` equals code bit 4 (0 = memory-to-VRAM or fill, 1 = VRAM copy), `mem_sel` is video (1) and `acc_write` is 1.
- R7: A code that matches neither R5 nor R6 is still latched unchanged in `acc_code`. It sets `code_bad`, with `mem_sel` = 0, `acc_write` = 0 and `dma_req` = 0. Codes whose bits 1:0 are 2'b10 cannot arise, because such a first word is a register command.
- R8: One cycle after a status read, `stat_rdata` = {6'b0, fifo_empty, fifo_full, stat_flags[7:0]}, with fifo_empty in bit 9 and fifo_full in bit 8. Otherwise `stat_rdata` holds its value.
- R9: After synchronous reset, every output is zero and no word is pending.
- R10: `addr_done` is high for exactly one cycle per completed second word, and it never coincides with `reg_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Control-port write enable |
| ctrl_wdata | input | 16 | Control-port write word |
| data_wr | input | 1 | Data-port write seen (clears pending) |
| stat_rd | input | 1 | Control-port read (status request) |
| fifo_empty | input | 1 | Write FIFO empty flag |
| fifo_full | input | 1 | Write FIFO full flag |
| stat_flags | input | 8 | Display flags: vint, sprite overflow, collision, odd frame, vblank, hblank, DMA busy, PAL (bit 7 down to 0) |
| reg_wr | output | 1 | Register-write strobe |
| reg_idx | output | 5 | Register number |
| reg_val | output | 8 | Register value |
| addr_done | output | 1 | Second-word completion strobe |
| addr | output | 16 | Assembled memory address |
| acc_code | output | 6 | Assembled access code |
| mem_sel | output | 2 | Target memory: 0 none, 1 video, 2 colour, 3 scroll |
| acc_write | output | 1 | Access is a write |
| dma_req | output | 1 | Code requests DMA |
| dma_copy | output | 1 | DMA is a VRAM copy |
| code_bad | output | 1 | Code not recognised |
| word_pending | output | 1 | First address word held |
| stat_rdata | output | 16 | Status word |

## Verification
Every result of this block is registered exactly once. The register strobe, the pending flag, the assembled address and code, their classification and the status word are therefore all due on the first clock edge after the stimulus cycle. The bench drives inputs on the falling edge and advances its model at that same point. It compares every output at the following falling edge, so each check lands one cycle after its stimulus and before the next stimulus is applied.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
  localparam int WORD_W = 16;
  localparam int CODE_W = 6;
  localparam int IDX_W  = 5;
  localparam int VAL_W  = 8;
  localparam int FLAG_W = 8;
  localparam int LOW_W  = 14;

  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_VRAM  = 2'd1,
    TGT_CRAM  = 2'd2,
    TGT_VSRAM = 2'd3
  } tgt_e;

  typedef struct packed {
    tgt_e tgt;
    logic wr;
    logic dma;
    logic copy;
    logic bad;
  } cls_t;
endpackage

// File: rtl/vpc_word_decoder.sv
module vpc_word_decoder
  import vpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              data_wr,
  input  logic              stat_rd,
  output logic              load,
  output logic [CODE_W-1:0] code_nxt,
  output logic              reg_wr_q,
  output logic [IDX_W-1:0]  idx_q,
  output logic [VAL_W-1:0]  val_q,
  output logic              done_q,
  output logic [WORD_W-1:0] addr_q,
  output logic [CODE_W-1:0] code_q,
  output logic              pend_q
);
  logic [WORD_W-1:0] first_q;
  logic              is_reg_cmd;

  assign is_reg_cmd = (wdata[15:14] == 2'b10);
  assign load       = ctrl_wr && pend_q;
  assign code_nxt   = {wdata[7:4], first_q[15:14]};

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q  <= '0;
      pend_q   <= 1'b0;
      reg_wr_q <= 1'b0;
      idx_q    <= '0;
      val_q    <= '0;
      done_q   <= 1'b0;
      addr_q   <= '0;
      code_q   <= '0;
    end else begin
      reg_wr_q <= 1'b0;
      done_q   <= 1'b0;
      if (ctrl_wr) begin
        if (pend_q) begin
          addr_q <= {wdata[1:0], first_q[LOW_W-1:0]};
          code_q <= code_nxt;
          done_q <= 1'b1;
          pend_q <= 1'b0;
        end else if (is_reg_cmd) begin
          reg_wr_q <= 1'b1;
          idx_q    <= wdata[12:8];
          val_q    <= wdata[7:0];
        end else begin
          first_q <= wdata;
          pend_q  <= 1'b1;
        end
      end else if (stat_rd || data_wr) begin
        pend_q <= 1'b0;
      end
    end
  end

  p_first_sets_pend_r2: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !pend_q && wdata[15:14] != 2'b10) |=> pend_q);
  p_second_done_r3: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && pend_q) |=> (done_q && !pend_q));
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !done_q |-> ($stable(addr_q) && $stable(code_q)));
  p_clear_pend_r4: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_wr && (stat_rd || data_wr)) |=> !pend_q);
  p_reg_no_pend_r1: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !pend_q && wdata[15:14] == 2'b10) |=> (reg_wr_q && !pend_q));
  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({reg_wr_q, done_q}));
endmodule

// File: rtl/vpc_code_class.sv
module vpc_code_class
  import vpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CODE_W-1:0] code,
  output cls_t              cls_q
);
  cls_t cls_d;

  always_comb begin
    cls_d = '{tgt: TGT_NONE, wr: 1'b0, dma: 1'b0, copy: 1'b0, bad: 1'b0};
    if (code[5]) begin
      cls_d.tgt  = TGT_VRAM;
      cls_d.wr   = 1'b1;
      cls_d.dma  = 1'b1;
      cls_d.copy = code[4];
    end else begin
      case (code[4:0])
        5'b00001: begin cls_d.tgt = TGT_VRAM;  cls_d.wr = 1'b1; end
        5'b00011: begin cls_d.tgt = TGT_CRAM;  cls_d.wr = 1'b1; end
        5'b00101: begin cls_d.tgt = TGT_VSRAM; cls_d.wr = 1'b1; end
        5'b00000: cls_d.tgt = TGT_VRAM;
        5'b01000: cls_d.tgt = TGT_CRAM;
        5'b00100: cls_d.tgt = TGT_VSRAM;
        default:  cls_d.bad = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cls_q <= '{tgt: TGT_NONE, wr: 1'b0, dma: 1'b0, copy: 1'b0, bad: 1'b0};
    else if (load) cls_q <= cls_d;
  end

  p_dma_target_r6: assert property (@(posedge clk) disable iff (rst)
    cls_q.dma |-> (cls_q.tgt == TGT_VRAM && cls_q.wr && !cls_q.bad));
  p_bad_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    cls_q.bad |-> (cls_q.tgt == TGT_NONE && !cls_q.wr && !cls_q.dma));
  p_cls_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(cls_q));
endmodule

// File: rtl/vpc_status_word.sv
module vpc_status_word
  import vpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              stat_rd,
  input  logic              fifo_empty,
  input  logic              fifo_full,
  input  logic [FLAG_W-1:0] flags,
  output logic [WORD_W-1:0] stat_q
);
  localparam int PAD_W = WORD_W - FLAG_W - 2;

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else if (stat_rd) stat_q <= {{PAD_W{1'b0}}, fifo_empty, fifo_full, flags};
  end

  p_stat_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !stat_rd |=> $stable(stat_q));
  p_stat_pad_r8: assert property (@(posedge clk) disable iff (rst)
    stat_q[WORD_W-1:FLAG_W+2] == '0);
endmodule

// File: rtl/vpc_ctrl_port.sv
module vpc_ctrl_port
  import vpc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        ctrl_wr,
  input  logic [15:0] ctrl_wdata,
  input  logic        data_wr,
  input  logic        stat_rd,
  input  logic        fifo_empty,
  input  logic        fifo_full,
  input  logic [7:0]  stat_flags,
  output logic        reg_wr,
  output logic [4:0]  reg_idx,
  output logic [7:0]  reg_val,
  output logic        addr_done,
  output logic [15:0] addr,
  output logic [5:0]  acc_code,
  output logic [1:0]  mem_sel,
  output logic        acc_write,
  output logic        dma_req,
  output logic        dma_copy,
  output logic        code_bad,
  output logic        word_pending,
  output logic [15:0] stat_rdata
);
  logic              load;
  logic [CODE_W-1:0] code_nxt;
  cls_t              cls;

  vpc_word_decoder u_dec (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .wdata(ctrl_wdata),
    .data_wr(data_wr), .stat_rd(stat_rd), .load(load), .code_nxt(code_nxt),
    .reg_wr_q(reg_wr), .idx_q(reg_idx), .val_q(reg_val), .done_q(addr_done),
    .addr_q(addr), .code_q(acc_code), .pend_q(word_pending)
  );

  vpc_code_class u_cls (
    .clk(clk), .rst(rst), .load(load), .code(code_nxt), .cls_q(cls)
  );

  vpc_status_word u_stat (
    .clk(clk), .rst(rst), .stat_rd(stat_rd), .fifo_empty(fifo_empty),
    .fifo_full(fifo_full), .flags(stat_flags), .stat_q(stat_rdata)
  );

  assign mem_sel   = cls.tgt;
  assign acc_write = cls.wr;
  assign dma_req   = cls.dma;
  assign dma_copy  = cls.copy;
  assign code_bad  = cls.bad;

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    addr_done |=> !addr_done);
  p_cls_with_done_r5: assert property (@(posedge clk) disable iff (rst)
    !addr_done |-> $stable(mem_sel));
endmodule

// File: tb/vpc_ctrl_port_tb.sv
`timescale 1ns/1ps
module vpc_ctrl_port_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctrl_wr = 1'b0, data_wr = 1'b0, stat_rd = 1'b0;
  logic [15:0] ctrl_wdata = '0;
  logic        fifo_empty = 1'b0, fifo_full = 1'b0;
  logic [7:0]  stat_flags = '0;
  logic        reg_wr, addr_done, acc_write, dma_req, dma_copy, code_bad, word_pending;
  logic [4:0]  reg_idx;
  logic [7:0]  reg_val;
  logic [15:0] addr, stat_rdata;
  logic [5:0]  acc_code;
  logic [1:0]  mem_sel;

  int tests = 0, fails = 0;
  bit fin = 1'b0;

  always #4 clk = ~clk;

  vpc_ctrl_port u_dut (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .data_wr(data_wr), .stat_rd(stat_rd), .fifo_empty(fifo_empty),
    .fifo_full(fifo_full), .stat_flags(stat_flags), .reg_wr(reg_wr),
    .reg_idx(reg_idx), .reg_val(reg_val), .addr_done(addr_done), .addr(addr),
    .acc_code(acc_code), .mem_sel(mem_sel), .acc_write(acc_write),
    .dma_req(dma_req), .dma_copy(dma_copy), .code_bad(code_bad),
    .word_pending(word_pending), .stat_rdata(stat_rdata)
  );

  // model state
  logic        e_pend, e_regwr, e_done;
  logic [15:0] e_first, e_addr, e_stat;
  logic [5:0]  e_code, e_cls;
  logic [4:0]  e_idx;
  logic [7:0]  e_val;
  string       ptag;

  // {sel[1:0], write, dma, copy, bad}
  function automatic logic [5:0] classify(input logic [5:0] c);
    if (c[5]) return {2'd1, 1'b1, 1'b1, c[4], 1'b0};
    case (c)
      6'b000001: return {2'd1, 4'b1000};
      6'b000011: return {2'd2, 4'b1000};
      6'b000101: return {2'd3, 4'b1000};
      6'b000000: return {2'd1, 4'b0000};
      6'b001000: return {2'd2, 4'b0000};
      6'b000100: return {2'd3, 4'b0000};
      default:   return {2'd0, 4'b0001};
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    string ctag;
    chk("R1 reg_wr", {31'b0, reg_wr}, {31'b0, e_regwr});
    chk("R1 reg_idx", {27'b0, reg_idx}, {27'b0, e_idx});
    chk("R1 reg_val", {24'b0, reg_val}, {24'b0, e_val});
    chk({ptag, " pending"}, {31'b0, word_pending}, {31'b0, e_pend});
    chk("R10 addr_done", {31'b0, addr_done}, {31'b0, e_done});
    chk("R3 addr", {16'b0, addr}, {16'b0, e_addr});
    chk("R3 acc_code", {26'b0, acc_code}, {26'b0, e_code});
    ctag = e_cls[2] ? "R6 class" : (e_cls[0] ? "R7 class" : "R5 class");
    chk(ctag, {26'b0, mem_sel, acc_write, dma_req, dma_copy, code_bad}, {26'b0, e_cls});
    chk("R8 stat", {16'b0, stat_rdata}, {16'b0, e_stat});
  endtask

  task automatic step(input logic cw, input logic [15:0] w, input logic dw, input logic sr);
    logic [5:0] c;
    ctrl_wr = cw; ctrl_wdata = w; data_wr = dw; stat_rd = sr;
    fifo_empty = 1'($urandom); fifo_full = 1'($urandom); stat_flags = 8'($urandom);
    e_regwr = 1'b0; e_done = 1'b0;
    if (cw) begin
      if (e_pend) begin
        e_addr = {w[1:0], e_first[13:0]};
        c = {w[7:4], e_first[15:14]};
        e_code = c; e_cls = classify(c);
        e_done = 1'b1; e_pend = 1'b0; ptag = "R3";
      end else if (w[15:14] == 2'b10) begin
        e_regwr = 1'b1; e_idx = w[12:8]; e_val = w[7:0]; ptag = "R1";
      end else begin
        e_first = w; e_pend = 1'b1; ptag = "R2";
      end
    end else if (sr || dw) begin
      e_pend = 1'b0; ptag = "R4";
    end
    if (sr) e_stat = {6'b0, fifo_empty, fifo_full, stat_flags};
    @(posedge clk);
    @(negedge clk);
    compare_all();
    ctrl_wr = 1'b0; data_wr = 1'b0; stat_rd = 1'b0;
  endtask

  task automatic addr_cmd(input logic [5:0] c, input logic [15:0] a);
    step(1'b1, {c[1:0], a[13:0]}, 1'b0, 1'b0);
    step(1'b1, {8'h00, c[5:2], 2'b00, a[15:14]}, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [5:0] pool [10];
    void'($urandom(32'd1234));
    pool = '{6'b000001, 6'b000011, 6'b000101, 6'b000000, 6'b001000,
             6'b000100, 6'b100001, 6'b110000, 6'b010000, 6'b000111};
    e_pend = 0; e_regwr = 0; e_done = 0; e_first = 0; e_addr = 0; e_stat = 0;
    e_code = 0; e_cls = 0; e_idx = 0; e_val = 0; ptag = "R9";
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk("R9 outputs", {reg_wr, addr_done, word_pending, acc_write, dma_req, dma_copy,
        code_bad, mem_sel, acc_code}, 32'h0);
    chk("R9 addr/stat", {addr, stat_rdata}, 32'h0);

    // R1 register command
    step(1'b1, 16'hBF5A, 1'b0, 1'b0);
    chk("R1 strobe high", {31'b0, reg_wr}, 32'h1);
    // R5 every table code
    addr_cmd(6'b000001, 16'hC123);
    addr_cmd(6'b000011, 16'h0001);
    addr_cmd(6'b000101, 16'h4FFF);
    addr_cmd(6'b000000, 16'h8000);
    addr_cmd(6'b001000, 16'h3ABC);
    addr_cmd(6'b000100, 16'h7777);
    // R6 DMA fill/mem and copy
    addr_cmd(6'b100001, 16'h1234);
    chk("R6 dma_req", {31'b0, dma_req}, 32'h1);
    addr_cmd(6'b110000, 16'hFFFF);
    chk("R6 dma_copy", {31'b0, dma_copy}, 32'h1);
    // R7 invalid codes latched unchanged
    addr_cmd(6'b010000, 16'h0F0F);
    chk("R7 code_bad", {31'b0, code_bad}, 32'h1);
    chk("R7 code kept", {26'b0, acc_code}, 32'h10);
    // R3 second word with top bits 10 and stray bits is still a second word
    step(1'b1, 16'h4005, 1'b0, 1'b0);
    step(1'b1, 16'hBF0E, 1'b0, 1'b0);
    chk("R3 no reg_wr", {31'b0, reg_wr}, 32'h0);
    chk("R3 addr", {16'b0, addr}, 32'h8005);
    // R2 first word alone changes no address
    step(1'b1, 16'h0123, 1'b0, 1'b0);
    chk("R2 addr unchanged", {16'b0, addr}, 32'h8005);
    // R4 clear by status read, then by data write
    step(1'b0, 16'h0, 1'b0, 1'b1);
    chk("R4 cleared by read", {31'b0, word_pending}, 32'h0);
    step(1'b1, 16'h0123, 1'b0, 1'b0);
    step(1'b0, 16'h0, 1'b1, 1'b0);
    chk("R4 cleared by data write", {31'b0, word_pending}, 32'h0);
    step(1'b1, 16'hBF01, 1'b0, 1'b0);
    chk("R4 reg cmd after clear", {31'b0, reg_wr}, 32'h1);
    // R4 precedence: control write with status read
    step(1'b1, 16'h0042, 1'b0, 1'b1);
    step(1'b1, 16'h0010, 1'b1, 1'b1);
    chk("R4 ctrl wins", {31'b0, addr_done}, 32'h1);
    // R8 status hold without read
    step(1'b0, 16'h0, 1'b0, 1'b0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int unsigned op;
      op = $urandom % 6;
      case (op)
        0: step(1'b1, {2'b10, 14'($urandom)}, 1'b0, ($urandom % 8) == 0);
        1: addr_cmd(pool[$urandom % 10], 16'($urandom));
        2: step(1'b1, 16'($urandom), ($urandom % 8) == 0, 1'b0);
        3: step(1'b0, 16'($urandom), 1'b0, 1'b1);
        4: step(1'b0, 16'($urandom), 1'b1, 1'b0);
        default: step(1'b0, 16'($urandom), 1'b0, 1'b0);
      endcase
    end

    fin = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule